// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit single-precision floating-point operands. Each operand is a sign bit, an 8-bit exponent stored with an offset of 127, and a 23-bit fraction that has an implied leading one. The unit returns a 32-bit product and three flags: overflow, underflow and invalid. The sign of the product is worked out apart from the magnitude. The two stored exponents are added and one offset of 127 is taken away. The two 24-bit significands, with the hidden one put back, are multiplied by a shift-and-add engine that takes one multiplier bit per clock. The 48-bit product is normalized in a single step and its fraction is truncated.

A request is a one-cycle `start` pulse with both operands present. The unit latches them, is busy for a fixed number of cycles, and then pulses `done`. The product and flags stay registered until the next completion. Operands whose exponent field is zero are treated as zero, and results too small to be normal are flushed to a signed zero. Exponent field 255 encodes infinity (fraction zero) or NaN (fraction nonzero). The quiet NaN produced by the unit is `0x7FC00000`.

Top module: `spMulUnit`

## Requirements
- R1: A `start` seen high at a rising edge while idle is accepted. `busy` is high from the next edge, and `done` goes high for exactly one cycle after the 26th rising edge, counting the accepting edge as the first. `busy` is low whenever `done` is high.
- R2: A `start` pulse while `busy` is high is ignored. `result` and the flags change only on the edge that raises `done`, and hold their values afterwards.
- R3: For every result that is not NaN, sign bit 31 of `result` equals the XOR of the two operand sign bits.
- R4: For two normal operands (exponent field 1..254), let P be the 48-bit product of the significands {1,fraction}. If P bit 47 is clear, the exponent is Ea+Eb-127 and the fraction is P[45:23]. If P bit 47 is set, the exponent is Ea+Eb-126 and the fraction is P[46:24]. There is no rounding.
- R5: If the final exponent from R4 is above 254, the result is an infinity (exponent field 255, fraction 0) with the R3 sign, and `ovf` is 1.
- R6: If the final exponent from R4 is 0 or less, the result is a zero (bits 30:0 all 0) with the R3 sign, and `unf` is 1.
- R7: A NaN operand, or a zero operand multiplied by an infinity, gives `result` = 0x7FC00000 and `inv` = 1.
- R8: An operand with exponent field 0 (zero or denormal) times a finite operand gives a zero with the R3 sign and no flag set.
- R9: An infinity times a nonzero finite value or an infinity gives an infinity with the R3 sign and no flag set.
- R10: After reset, `busy`, `done`, `result`, `ovf`, `unf` and `inv` are all 0, and at most one flag is ever high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; operands are sampled with it |
| opA | input | 32 | Multiplicand, single-precision |
| opB | input | 32 | Multiplier, single-precision |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Registered product |
| ovf | output | 1 | Exponent overflow, result is infinity |
| unf | output | 1 | Exponent underflow, result is zero |
| inv | output | 1 | Invalid operation, result is quiet NaN |

## Verification
Every product and flag is due exactly 26 rising edges after the edge that accepts `start`. The bench raises `start` at a falling edge, counts rising edges while it watches `done` at each falling edge, and compares that count with 26 before it compares the product and flags against its own reference model. After each completion the bench waits several more falling edges and checks that the result is unchanged. One run sends a second `start` halfway through an operation and expects the product of the first operands, on the first operation's schedule.

// File: rtl/spMulPkg.sv
package spMulPkg;

  typedef struct packed {
    logic load;    // latch operands, seed the product register
    logic step;    // one shift-and-add iteration
    logic finish;  // normalize, pack and register the result
  } mulStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_FIN  = 2'd2
  } mulState_t;

endpackage

// File: rtl/spMulClass.sv
module spMulClass #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output logic                  sign,
  output logic [EXP_W-1:0]      expField,
  output logic [FRAC_W:0]       sig,
  output logic                  isZero,
  output logic                  isInf,
  output logic                  isNan
);
  localparam int WORD_W = EXP_W + FRAC_W + 1;

  logic [FRAC_W-1:0] frac;
  logic              expAllOnes;

  always_comb begin
    sign       = word[WORD_W-1];
    expField   = word[WORD_W-2 -: EXP_W];
    frac       = word[FRAC_W-1:0];
    expAllOnes = &expField;
    // exponent field 0 covers zero and denormals; both count as zero
    isZero     = (expField == '0);
    isInf      = expAllOnes && (frac == '0);
    isNan      = expAllOnes && (frac != '0);
    sig        = isZero ? '0 : {1'b1, frac};
  end

endmodule

// File: rtl/spMulCtrl.sv
module spMulCtrl
  import spMulPkg::*;
#(
  parameter int SIG_W = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output mulStrobes_t strobes,
  output logic        busy,
  output logic        done
);
  localparam int CNT_W = $clog2(SIG_W + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(SIG_W - 1);

  mulState_t        state;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strobes.load   = (state == ST_IDLE) && start;
    strobes.step   = (state == ST_MUL);
    strobes.finish = (state == ST_FIN);
    busy           = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobes.finish;
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_MUL;
          stepCnt <= '0;
        end
        ST_MUL: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: the completion pulse lasts one cycle and never overlaps busy
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R1: the finishing state is reached only from the iteration state
  p_fin_after_mul_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIN) |-> ($past(state) == ST_MUL));
  // R2: a start while busy does not restart the iteration count
  p_no_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MUL && start && stepCnt != LAST_STEP) |=> (stepCnt != '0));

endmodule

// File: rtl/spMulPath.sv
module spMulPath
  import spMulPkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  mulStrobes_t           strobes,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  ovf,
  output logic                  unf,
  output logic                  inv
);
  localparam int WORD_W   = EXP_W + FRAC_W + 1;
  localparam int SIG_W    = FRAC_W + 1;
  localparam int PROD_W   = 2 * SIG_W;
  localparam int EW       = EXP_W + 2;
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_TOP  = (1 << EXP_W) - 2;   // largest normal field

  logic [WORD_W-1:0] aReg, bReg;
  logic [PROD_W-1:0] prod;

  logic              signA, signB, zeroA, zeroB, infA, infB, nanA, nanB;
  logic [EXP_W-1:0]  expA, expB;
  logic [SIG_W-1:0]  sigA, sigB;

  spMulClass #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classA (
    .word(aReg), .sign(signA), .expField(expA), .sig(sigA),
    .isZero(zeroA), .isInf(infA), .isNan(nanA));

  spMulClass #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classB (
    .word(bReg), .sign(signB), .expField(expB), .sig(sigB),
    .isZero(zeroB), .isInf(infB), .isNan(nanB));

  // shift-and-add: the multiplier occupies the low half and is consumed LSB first
  logic [SIG_W:0] partSum;
  always_comb begin
    partSum = {1'b0, prod[PROD_W-1:SIG_W]} + (prod[0] ? {1'b0, sigA} : '0);
  end

  // normalization and packing
  logic                     prodTop;
  logic [FRAC_W-1:0]        fracNorm;
  logic signed [EW-1:0]     expSum, expAdj;
  logic                     signOut;
  logic [WORD_W-1:0]        packed_n;
  logic                     ovf_n, unf_n, inv_n;

  always_comb begin
    prodTop  = prod[PROD_W-1];
    fracNorm = prodTop ? prod[PROD_W-2 -: FRAC_W] : prod[PROD_W-3 -: FRAC_W];
    expSum   = EW'(expA) + EW'(expB) - EW'(BIAS);
    expAdj   = expSum + EW'(prodTop);
    signOut  = signA ^ signB;
    ovf_n    = 1'b0;
    unf_n    = 1'b0;
    inv_n    = 1'b0;
    if (nanA || nanB || (zeroA && infB) || (infA && zeroB)) begin
      inv_n    = 1'b1;
      packed_n = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    end else if (infA || infB) begin
      packed_n = {signOut, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (zeroA || zeroB) begin
      packed_n = {signOut, {(WORD_W-1){1'b0}}};
    end else if (expAdj > EXP_TOP) begin
      ovf_n    = 1'b1;
      packed_n = {signOut, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (expAdj < 1) begin
      unf_n    = 1'b1;
      packed_n = {signOut, {(WORD_W-1){1'b0}}};
    end else begin
      packed_n = {signOut, expAdj[EXP_W-1:0], fracNorm};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg   <= '0;
      bReg   <= '0;
      prod   <= '0;
      result <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
      inv    <= 1'b0;
    end else begin
      if (strobes.load) begin
        aReg <= opA;
        bReg <= opB;
        prod <= {{SIG_W{1'b0}}, ((opB[WORD_W-2 -: EXP_W] == '0) ? {SIG_W{1'b0}}
                                 : {1'b1, opB[FRAC_W-1:0]})};
      end else if (strobes.step) begin
        prod <= {partSum, prod[SIG_W-1:1]};
      end
      if (strobes.finish) begin
        result <= packed_n;
        ovf    <= ovf_n;
        unf    <= unf_n;
        inv    <= inv_n;
      end
    end
  end

  // R5: overflow always comes with an infinity
  p_ovf_inf_r5: assert property (@(posedge clk) disable iff (!rstN)
    ovf |-> (result[WORD_W-2 -: EXP_W] == {EXP_W{1'b1}} && result[FRAC_W-1:0] == '0));
  // R6: underflow always comes with a zero magnitude
  p_unf_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    unf |-> (result[WORD_W-2:0] == '0));
  // R7: invalid always comes with the quiet NaN pattern
  p_inv_nan_r7: assert property (@(posedge clk) disable iff (!rstN)
    inv |-> (result == {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}));
  // R10: the flags are mutually exclusive
  p_one_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ovf, unf, inv}));
  // R4: a normal product never carries exponent field 0
  p_norm_exp_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!unf && !inv && result[WORD_W-2:0] != '0) |-> (result[WORD_W-2 -: EXP_W] != '0));

endmodule

// File: rtl/spMulUnit.sv
module spMulUnit
  import spMulPkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  output logic                  busy,
  output logic                  done,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  ovf,
  output logic                  unf,
  output logic                  inv
);
  localparam int SIG_W = FRAC_W + 1;

  mulStrobes_t strobes;

  spMulCtrl #(.SIG_W(SIG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobes(strobes), .busy(busy), .done(done));

  spMulPath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .opA(opA), .opB(opB),
    .result(result), .ovf(ovf), .unf(unf), .inv(inv));

  // R2: the product only moves on the edge that raises done
  p_result_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> (done || $stable(result)));
  // R2: flags follow the same rule
  p_flags_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> (done || $stable({ovf, unf, inv})));

endmodule

// File: tb/sim_spMulUnit.sv
module sim_spMulUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        busy, done, ovf, unf, inv;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  int cycleCount = 0;

  localparam int LATENCY = 26;

  spMulUnit u0 (.clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
                .busy(busy), .done(done), .result(result),
                .ovf(ovf), .unf(unf), .inv(inv));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (cycleCount > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, cycles %0d expected below 150000", cycleCount);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  // reference model: returns {ovf, unf, inv, result}
  function automatic logic [34:0] refMul(input logic [31:0] a, input logic [31:0] b);
    logic        sa, sb, so, za, zb, ia, ib, na, nb;
    logic [7:0]  ea, eb;
    logic [63:0] p;
    int          e;
    logic [22:0] f;
    sa = a[31]; sb = b[31]; so = sa ^ sb;
    ea = a[30:23]; eb = b[30:23];
    za = (ea == 0); zb = (eb == 0);
    ia = (ea == 8'hFF) && (a[22:0] == 0); ib = (eb == 8'hFF) && (b[22:0] == 0);
    na = (ea == 8'hFF) && (a[22:0] != 0); nb = (eb == 8'hFF) && (b[22:0] != 0);
    if (na || nb || (za && ib) || (ia && zb)) return {3'b001, 32'h7FC00000};
    if (ia || ib) return {3'b000, so, 8'hFF, 23'd0};
    if (za || zb) return {3'b000, so, 31'd0};
    p = {40'd0, 1'b1, a[22:0]} * {40'd0, 1'b1, b[22:0]};
    e = int'(ea) + int'(eb) - 127;
    if (p[47]) begin e = e + 1; f = p[46:24]; end
    else f = p[45:23];
    if (e > 254) return {3'b100, so, 8'hFF, 23'd0};
    if (e < 1)   return {3'b010, so, 31'd0};
    return {3'b000, so, e[7:0], f};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one full operation; optional interfering start after midStart cycles
  task automatic runOp(input string tag, input logic [31:0] a, input logic [31:0] b,
                       input bit interfere);
    logic [34:0] expv;
    int          cyc;
    expv = refMul(a, b);
    @(negedge clk);
    opA = a; opB = b; start = 1'b1;
    cyc = 0;
    @(posedge clk); cyc++;
    @(negedge clk);
    start = 1'b0;
    check("R1 busy after accept", 64'(busy), 64'd1);
    while (!done && cyc < 60) begin
      if (interfere && cyc == 10) begin
        opA = 32'h40400000; opB = 32'h40400000; start = 1'b1;   // R2 stray start
      end else begin
        start = 1'b0;
      end
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    check("R1 latency", 64'(cyc), 64'(LATENCY));
    check(tag, 64'(result), 64'(expv[31:0]));
    check({tag, " flags"}, 64'({ovf, unf, inv}), 64'(expv[34:32]));
    @(negedge clk);
    check("R1 done one cycle", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    check("R2 result held", 64'({ovf, unf, inv, result}), 64'(expv));
  endtask

  function automatic logic [31:0] pickOperand();
    int          kind;
    logic [7:0]  e;
    kind = int'($urandom_range(0, 15));
    case (kind)
      0: return {1'($urandom), 31'd0};
      1: return {1'($urandom), 8'hFF, 23'd0};
      2: return {1'($urandom), 8'hFF, 23'($urandom) | 23'd1};
      3: return {1'($urandom), 8'd0, 23'($urandom)};
      4, 5: begin
        e = 8'($urandom_range(1, 254));
        return {1'($urandom), e, 23'($urandom)};
      end
      default: begin
        e = 8'($urandom_range(70, 185));
        return {1'($urandom), e, 23'($urandom)};
      end
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R10 reset outputs", 64'({busy, done, ovf, unf, inv, result}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 idle after release", 64'({busy, done}), 64'd0);

    runOp("R4 one times one",        32'h3F800000, 32'h3F800000, 1'b0);
    runOp("R4 carry into bit 47",    32'h3FC00000, 32'h3FC00000, 1'b0);
    runOp("R4 two times three",      32'h40000000, 32'h40400000, 1'b0);
    runOp("R3 negative product",     32'hC0000000, 32'h40400000, 1'b0);
    runOp("R3 two negatives",        32'hBFC00000, 32'hC0A00000, 1'b0);
    runOp("R4 truncation",           32'h3FFFFFFF, 32'h3FFFFFFF, 1'b0);
    runOp("R4 top normal exponent",  32'h7F000000, 32'h3F800000, 1'b0);
    runOp("R4 lowest normal",        32'h00800000, 32'h3F800000, 1'b0);
    runOp("R5 large overflow",       32'h7F000000, 32'h7F000000, 1'b0);
    runOp("R5 overflow by carry",    32'h7F7FFFFF, 32'h3FFFFFFF, 1'b0);
    runOp("R6 underflow",            32'h00800000, 32'h00800000, 1'b0);
    runOp("R6 signed underflow",     32'h80800000, 32'h00800000, 1'b0);
    runOp("R6 exponent exactly 0",   32'h3F000000, 32'h00800000, 1'b0);
    runOp("R7 NaN operand",          32'h7FC00001, 32'h3F800000, 1'b0);
    runOp("R7 zero times infinity",  32'h00000000, 32'hFF800000, 1'b0);
    runOp("R7 NaN times infinity",   32'h7F800000, 32'hFF812345, 1'b0);
    runOp("R8 zero times negative",  32'h00000000, 32'hC0A00000, 1'b0);
    runOp("R8 denormal as zero",     32'h00000001, 32'h40000000, 1'b0);
    runOp("R9 infinity times neg",   32'h7F800000, 32'hC0000000, 1'b0);
    runOp("R9 infinity squared",     32'hFF800000, 32'hFF800000, 1'b0);
    runOp("R2 stray start ignored",  32'h40000000, 32'h40A00000, 1'b1);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      a = pickOperand();
      b = pickOperand();
      runOp("R3 R4 random", a, b, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule